// File: doc/BRIEF.md
# Command Descriptor Address Generator

This block sits between a remote terminal's command decoder and the shared RAM that holds the per-command descriptor table. When the decoder hands over a validated 16-bit command word, the block works out which four-word descriptor block governs that command. It records the address of that block's control word as the current control word address. It then reads the four descriptor words from a synchronous RAM port and presents them to the message-processing logic.

Once message processing has finished and supplies an updated control word, the block writes that word back into the first word of the same descriptor block. It then becomes free to take the next command.

The table spans word addresses 0x0200 to 0x03FF and is divided into four 32-block regions. Ordinary subaddress commands are indexed by their subaddress. Commands with subaddress 0 or 31 are mode commands and are indexed by their mode code in a separate pair of regions. In both cases the transmit/receive bit picks which region of the pair is used.

Top module: `cdesc_agen`

## Requirements
- R1: A command with bit 10 (transmit/receive) = 0 and subaddress bits 9:5 in 1..30 maps to control word address 0x0200 + 4 × subaddress. Bits 15:11 and 4:0 do not affect the address.
- R2: A command with bit 10 = 1 and subaddress 1..30 maps to 0x0280 + 4 × subaddress.
- R3: A command whose subaddress is 0 or 31 maps to 0x0300 + 4 × mode code (bits 4:0) when bit 10 = 0, and to 0x0380 + 4 × mode code when bit 10 = 1. Subaddresses 0 and 31 give the same address.
- R4: `cur_addr` takes the computed address on the clock edge where `cmd_valid` is high and `busy` is low. At all other times it holds its value.
- R5: Starting in the cycle after acceptance, the block issues exactly four reads (`ram_rd` high), one per cycle, to addresses `cur_addr`+0 through `cur_addr`+3 in that order. The RAM returns data one cycle after each read.
- R6: `desc_ready` is high for exactly one cycle, the fifth cycle after the acceptance edge. From then on, `desc_words` bits 16k+15:16k hold the RAM word at `cur_addr`+k, for k = 0..3.
- R7: `busy` is high from the cycle after acceptance until the write-back cycle has completed. A `cmd_valid` raised while `busy` is high is ignored: no new reads, and `cur_addr` does not change.
- R8: A `done_valid` pulse after `desc_ready` causes exactly one write (`ram_wr` high) in the following cycle, of `done_ctrl` to `cur_addr`. `busy` is low in the cycle after the write.
- R9: `done_valid` is ignored when no descriptor is being held: no write is issued.
- R10: After reset, `busy`, `desc_ready`, `ram_rd` and `ram_wr` are low and `cur_addr` is 0x0000.
- R11: `ram_rd` and `ram_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Validated command word |
| busy | output | 1 | High while a command is being handled |
| done_valid | input | 1 | Message processing complete strobe |
| done_ctrl | input | 16 | Updated control word to write back |
| ram_rd | output | 1 | RAM read request |
| ram_wr | output | 1 | RAM write request |
| ram_addr | output | 16 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after `ram_rd` |
| desc_ready | output | 1 | One-cycle pulse: descriptor words captured |
| desc_words | output | 64 | Four captured descriptor words, word k in bits 16k+15:16k |
| cur_addr | output | 16 | Current control word address |

## Verification
A wrong quadrant or index decision appears on `cur_addr` half a cycle after the acceptance edge. The same error carries into the four read addresses over the next four cycles. A slip in the read pipeline puts a neighbouring RAM word into the wrong `desc_words` slot, or moves `desc_ready` off the fifth cycle; either is visible the moment the pulse appears. A sequencer stuck in the wrong state shows up as missing or extra reads or writes, or as `busy` failing to fall one cycle after the write-back. Checks for these run against the bench's own RAM model.

// File: rtl/cdesc_pkg.sv
package cdesc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_HOLD  = 2'd2,
        ST_WBACK = 2'd3
    } cdesc_state_e;

    typedef struct packed {
        logic [4:0] rt;
        logic       tr;
        logic [4:0] sa;
        logic [4:0] low;
    } cmd_word_t;

endpackage

// File: rtl/cdesc_addr_calc.sv
module cdesc_addr_calc #(
    parameter int          ADDR_W     = 16,
    parameter int          BLK_WORDS  = 4,
    parameter logic [15:0] TABLE_BASE = 16'h0200
) (
    input  logic              tr,
    input  logic [4:0]        sa,
    input  logic [4:0]        low,
    output logic [ADDR_W-1:0] blk_addr
);
    localparam int IDX_W   = 5;
    localparam int BLK_SH  = $clog2(BLK_WORDS);
    localparam int QUAD_SH = IDX_W + BLK_SH;

    logic       is_mode;
    logic [1:0] quad;
    logic [4:0] idx;

    always_comb begin
        is_mode  = (sa == 5'd0) || (sa == 5'd31);
        quad     = {is_mode, tr};
        idx      = is_mode ? low : sa;
        blk_addr = ADDR_W'(TABLE_BASE)
                 + (ADDR_W'(quad) << QUAD_SH)
                 + (ADDR_W'(idx) << BLK_SH);
    end
endmodule

// File: rtl/cdesc_seq.sv
module cdesc_seq
    import cdesc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int BLK_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] blk_addr,
    input  logic              done_valid,
    input  logic [DATA_W-1:0] done_ctrl,
    output logic              busy,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              cap_en,
    output logic [$clog2(BLK_WORDS)-1:0] cap_idx,
    output logic              ready,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int                CNT_W = $clog2(BLK_WORDS);
    localparam logic [CNT_W:0]    N_RD  = (CNT_W+1)'(BLK_WORDS);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BLK_WORDS - 1);

    typedef struct packed {
        cdesc_state_e      state;
        logic [ADDR_W-1:0] cur_addr;
        logic [CNT_W:0]    issue_cnt;
        logic              pend;
        logic [CNT_W-1:0]  pend_idx;
        logic              ready;
        logic [DATA_W-1:0] wdata;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.ready = 1'b0;
        s_d.pend  = 1'b0;
        ram_rd    = 1'b0;
        ram_wr    = 1'b0;
        ram_addr  = s_q.cur_addr;
        ram_wdata = s_q.wdata;
        case (s_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.state     = ST_FETCH;
                    s_d.cur_addr  = blk_addr;
                    s_d.issue_cnt = '0;
                end
            end
            ST_FETCH: begin
                if (s_q.issue_cnt < N_RD) begin
                    ram_rd        = 1'b1;
                    ram_addr      = s_q.cur_addr + ADDR_W'(s_q.issue_cnt);
                    s_d.pend      = 1'b1;
                    s_d.pend_idx  = s_q.issue_cnt[CNT_W-1:0];
                    s_d.issue_cnt = s_q.issue_cnt + 1'b1;
                end
                if (s_q.pend && (s_q.pend_idx == LAST)) begin
                    s_d.state = ST_HOLD;
                    s_d.ready = 1'b1;
                end
            end
            ST_HOLD: begin
                if (done_valid) begin
                    s_d.wdata = done_ctrl;
                    s_d.state = ST_WBACK;
                end
            end
            ST_WBACK: begin
                ram_wr    = 1'b1;
                s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state     <= ST_IDLE;
            s_q.cur_addr  <= '0;
            s_q.issue_cnt <= '0;
            s_q.pend      <= 1'b0;
            s_q.pend_idx  <= '0;
            s_q.ready     <= 1'b0;
            s_q.wdata     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.state != ST_IDLE);
    assign cap_en   = s_q.pend;
    assign cap_idx  = s_q.pend_idx;
    assign ready    = s_q.ready;
    assign cur_addr = s_q.cur_addr;

    // R11: reads and writes never share a cycle
    a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_wr));

    // R6: ready is a single-cycle pulse
    a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R7: ready only appears while a command is owned
    a_r7_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> busy);

    // R8: a write always follows a completion strobe
    a_r8_wr_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> $past(done_valid));

    // R8: busy drops right after the write
    a_r8_idle_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |=> !busy);
endmodule

// File: rtl/cdesc_capture.sv
module cdesc_capture #(
    parameter int DATA_W    = 16,
    parameter int BLK_WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cap_en,
    input  logic [$clog2(BLK_WORDS)-1:0]  cap_idx,
    input  logic [DATA_W-1:0]             rdata,
    output logic [BLK_WORDS*DATA_W-1:0]   words
);
    logic [DATA_W-1:0] w_d [BLK_WORDS];
    logic [DATA_W-1:0] w_q [BLK_WORDS];

    for (genvar k = 0; k < BLK_WORDS; k++) begin : g_word
        always_comb begin
            w_d[k] = w_q[k];
            if (cap_en && (cap_idx == k[$clog2(BLK_WORDS)-1:0]))
                w_d[k] = rdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) w_q[k] <= '0;
            else        w_q[k] <= w_d[k];
        end

        assign words[k*DATA_W +: DATA_W] = w_q[k];
    end
endmodule

// File: rtl/cdesc_agen.sv
module cdesc_agen #(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 16,
    parameter int          BLK_WORDS  = 4,
    parameter logic [15:0] TABLE_BASE = 16'h0200
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [15:0]                 cmd_word,
    output logic                        busy,
    input  logic                        done_valid,
    input  logic [DATA_W-1:0]           done_ctrl,
    output logic                        ram_rd,
    output logic                        ram_wr,
    output logic [ADDR_W-1:0]           ram_addr,
    output logic [DATA_W-1:0]           ram_wdata,
    input  logic [DATA_W-1:0]           ram_rdata,
    output logic                        desc_ready,
    output logic [BLK_WORDS*DATA_W-1:0] desc_words,
    output logic [ADDR_W-1:0]           cur_addr
);
    localparam int CNT_W    = $clog2(BLK_WORDS);
    localparam int TBL_SPAN = 4 * 32 * BLK_WORDS;

    cdesc_pkg::cmd_word_t cmd_s;
    logic [ADDR_W-1:0]    blk_addr;
    logic                 cap_en;
    logic [CNT_W-1:0]     cap_idx;
    logic                 rt_unused;

    assign cmd_s     = cmd_word;
    assign rt_unused = ^cmd_s.rt;

    cdesc_addr_calc #(
        .ADDR_W    (ADDR_W),
        .BLK_WORDS (BLK_WORDS),
        .TABLE_BASE(TABLE_BASE)
    ) u_calc (
        .tr      (cmd_s.tr),
        .sa      (cmd_s.sa),
        .low     (cmd_s.low),
        .blk_addr(blk_addr)
    );

    cdesc_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BLK_WORDS(BLK_WORDS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .blk_addr  (blk_addr),
        .done_valid(done_valid),
        .done_ctrl (done_ctrl),
        .busy      (busy),
        .ram_rd    (ram_rd),
        .ram_wr    (ram_wr),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .ready     (desc_ready),
        .cur_addr  (cur_addr)
    );

    cdesc_capture #(
        .DATA_W   (DATA_W),
        .BLK_WORDS(BLK_WORDS)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .cap_idx(cap_idx),
        .rdata  (ram_rdata),
        .words  (desc_words)
    );

    // R4: a command offered while busy leaves the current address alone
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(cur_addr));

    // R1: an owned address lies inside the table and on a block boundary
    a_r1_addr_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((cur_addr >= ADDR_W'(TABLE_BASE))
              && (cur_addr <  ADDR_W'(TABLE_BASE) + ADDR_W'(TBL_SPAN))
              && (cur_addr[CNT_W-1:0] == '0)));

    // R5: every read stays within the owned block
    a_r5_rd_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |-> ((ram_addr - cur_addr) < ADDR_W'(BLK_WORDS)));
endmodule

// File: tb/cdesc_agen_tb.sv
module cdesc_agen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        done_valid = 1'b0;
    logic [15:0] done_ctrl = '0;
    logic [15:0] ram_rdata = '0;
    logic        busy, ram_rd, ram_wr, desc_ready;
    logic [15:0] ram_addr, ram_wdata, cur_addr;
    logic [63:0] desc_words;

    logic [15:0] mem [0:1023];
    logic [15:0] rd_log [0:255];
    int rd_cnt = 0;
    int wr_cnt = 0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cdesc_agen u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .busy(busy), .done_valid(done_valid), .done_ctrl(done_ctrl),
        .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .desc_ready(desc_ready), .desc_words(desc_words), .cur_addr(cur_addr)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 16'(i * 16'h0107) ^ 16'h5A00;
        end else begin
            if (ram_rd) begin
                ram_rdata <= mem[ram_addr[9:0]];
                if (rd_cnt < 256) rd_log[rd_cnt] <= ram_addr;
                rd_cnt <= rd_cnt + 1;
            end
            if (ram_wr) begin
                mem[ram_addr[9:0]] <= ram_wdata;
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mkcw(input logic [4:0] rt, input logic tr,
                                         input logic [4:0] sa, input logic [4:0] low);
        return {rt, tr, sa, low};
    endfunction

    // Expected address from R1..R3
    function automatic logic [15:0] exp_addr(input logic tr, input logic [4:0] sa,
                                             input logic [4:0] low);
        logic [15:0] base;
        logic [4:0]  idx;
        if (sa == 5'd0 || sa == 5'd31) begin
            base = tr ? 16'h0380 : 16'h0300;
            idx  = low;
        end else begin
            base = tr ? 16'h0280 : 16'h0200;
            idx  = sa;
        end
        return base + 16'(idx) * 16'd4;
    endfunction

    // Accept a command, follow the fetch, check address, reads and words
    task automatic fetch_cmd(input logic [15:0] cw, input logic [15:0] exp, input string req);
        int rd0;
        int n;
        rd0 = rd_cnt;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = cw;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cur_addr == exp, req, "cur_addr", 32'(cur_addr), 32'(exp));
        check(busy == 1'b1, "R7", "busy after accept", 32'(busy), 32'd1);
        n = 0;
        while (!desc_ready && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(n == 5, "R6", "ready delay", 32'(n), 32'd5);
        check(rd_cnt - rd0 == 4, "R5", "read count", 32'(rd_cnt - rd0), 32'd4);
        for (int k = 0; k < 4; k++) begin
            check(rd_log[rd0 + k] == exp + 16'(k), "R5", "read address",
                  32'(rd_log[rd0 + k]), 32'(exp + 16'(k)));
            check(desc_words[16*k +: 16] == mem[10'(exp + 16'(k))], "R6", "desc word",
                  32'(desc_words[16*k +: 16]), 32'(mem[10'(exp + 16'(k))]));
        end
        @(negedge clk);
        check(desc_ready == 1'b0, "R6", "ready width", 32'(desc_ready), 32'd0);
    endtask

    task automatic finish_cmd(input logic [15:0] val);
        int wr0;
        logic [15:0] a;
        wr0 = wr_cnt;
        a = cur_addr;
        done_valid = 1'b1;
        done_ctrl  = val;
        @(negedge clk);
        done_valid = 1'b0;
        check(ram_wr == 1'b1 && ram_addr == a, "R8", "write cycle",
              {15'd0, ram_wr, ram_addr}, {15'd0, 1'b1, a});
        @(negedge clk);
        check(mem[a[9:0]] == val, "R8", "written word", 32'(mem[a[9:0]]), 32'(val));
        check(wr_cnt - wr0 == 1, "R8", "write count", 32'(wr_cnt - wr0), 32'd1);
        check(busy == 1'b0, "R8", "busy after write", 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R10", "busy", 32'(busy), 32'd0);
        check(desc_ready == 1'b0, "R10", "ready", 32'(desc_ready), 32'd0);
        check(ram_rd == 1'b0 && ram_wr == 1'b0, "R10", "rd/wr",
              {ram_rd, ram_wr}, 32'd0);
        check(cur_addr == 16'h0000, "R10", "cur_addr", 32'(cur_addr), 32'd0);
    endtask

    task automatic t_rx_sub();
        fetch_cmd(mkcw(5'd3, 1'b0, 5'd1, 5'd7), exp_addr(1'b0, 5'd1, 5'd7), "R1");
        finish_cmd(16'h1111);
        fetch_cmd(mkcw(5'd31, 1'b0, 5'd30, 5'd0), exp_addr(1'b0, 5'd30, 5'd0), "R1");
        finish_cmd(16'h2222);
    endtask

    task automatic t_tx_sub();
        fetch_cmd(mkcw(5'd9, 1'b1, 5'd12, 5'd31), exp_addr(1'b1, 5'd12, 5'd31), "R2");
        finish_cmd(16'h3333);
    endtask

    task automatic t_mode();
        fetch_cmd(mkcw(5'd1, 1'b1, 5'd0, 5'd2), exp_addr(1'b1, 5'd0, 5'd2), "R3");
        finish_cmd(16'h4444);
        fetch_cmd(mkcw(5'd1, 1'b1, 5'd31, 5'd2), exp_addr(1'b1, 5'd31, 5'd2), "R3");
        finish_cmd(16'h4445);
        fetch_cmd(mkcw(5'd2, 1'b0, 5'd31, 5'd17), exp_addr(1'b0, 5'd31, 5'd17), "R3");
        finish_cmd(16'h5555);
        fetch_cmd(mkcw(5'd2, 1'b1, 5'd0, 5'd31), exp_addr(1'b1, 5'd0, 5'd31), "R3");
        finish_cmd(16'h6666);
    endtask

    task automatic t_busy_ignore();
        int rd0;
        logic [15:0] a;
        rd0 = rd_cnt;
        a = exp_addr(1'b0, 5'd5, 5'd0);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = mkcw(5'd4, 1'b0, 5'd5, 5'd0);
        @(negedge clk);
        cmd_word  = mkcw(5'd4, 1'b1, 5'd20, 5'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cur_addr == a, "R4", "addr held during fetch", 32'(cur_addr), 32'(a));
        while (!desc_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = mkcw(5'd4, 1'b1, 5'd0, 5'd9);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        check(cur_addr == a, "R7", "addr held while holding", 32'(cur_addr), 32'(a));
        check(rd_cnt - rd0 == 4, "R7", "no extra reads", 32'(rd_cnt - rd0), 32'd4);
        check(busy == 1'b1, "R7", "busy while holding", 32'(busy), 32'd1);
        finish_cmd(16'hBEEF);
        // write-back visible on next fetch of the same block
        fetch_cmd(mkcw(5'd0, 1'b0, 5'd5, 5'd3), a, "R1");
        check(desc_words[15:0] == 16'hBEEF, "R8", "readback", 32'(desc_words[15:0]), 32'hBEEF);
        finish_cmd(16'h0F0F);
    endtask

    task automatic t_stray_done();
        int wr0;
        int rd0;
        wr0 = wr_cnt;
        rd0 = rd_cnt;
        @(negedge clk);
        done_valid = 1'b1;
        done_ctrl  = 16'hDEAD;
        @(negedge clk);
        done_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(wr_cnt == wr0, "R9", "no write when idle", 32'(wr_cnt - wr0), 32'd0);
        check(rd_cnt == rd0, "R9", "no read when idle", 32'(rd_cnt - rd0), 32'd0);
        check(busy == 1'b0, "R9", "stays idle", 32'(busy), 32'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_rx_sub();
                t_tx_sub();
                t_mode();
                t_busy_ignore();
                t_stray_done();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule